// File: doc/BRIEF.md
# Guard Predicate File with Commit Nullification

This block keeps a bank of one-bit guard flags and rules on each instruction as it leaves the pipeline. A compare micro-op delivers one condition bit and two destination indices. The condition goes into the first destination and its inverse goes into the second, both in the same cycle. Every retiring instruction carries a 6-bit guard index. One cycle later the block raises either a commit strobe or a squash strobe for it. A squashed instruction acts as a no-op: the surrounding pipeline drops its register write and does not retire its result.

Flag 0 always reads true and cannot be written, so unguarded instructions name index 0. A compare that lands in the same cycle as a guard read of the same index is forwarded to that read. If both destination indices of a compare are equal, the condition value is the one stored.

Top module: `pred_guard_file`

## Requirements
- R1: After reset, flags 1 to 63 read false, so a guarded instruction that names any of them is squashed. commit_valid, commit_ok and squash are all low after reset.
- R2: commit_valid is high in the cycle after insn_valid was high and low in the cycle after insn_valid was low.
- R3: When commit_valid is high, exactly one of commit_ok and squash is high. When commit_valid is low, both are low.
- R4: Guard index 0 always reads true, and compare writes that target index 0 have no effect, so an instruction guarded by index 0 always commits.
- R5: A compare with cmp_we high stores cmp_result into flag cmp_dst_t and the inverse of cmp_result into flag cmp_dst_f at the clock edge.
- R6: A guard read whose index matches a destination of a compare in the same cycle sees the value that compare writes, not the stored one.
- R7: When cmp_dst_t equals cmp_dst_f, that flag takes cmp_result. This applies both to the stored value and to the forwarded value.
- R8: A flag that no compare names keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Compare result write enable |
| cmp_dst_t | input | 6 | Index that receives the condition |
| cmp_dst_f | input | 6 | Index that receives the inverted condition |
| cmp_result | input | 1 | Condition bit from the compare |
| insn_valid | input | 1 | A retiring instruction is present |
| insn_guard | input | 6 | Guard index of the retiring instruction |
| commit_valid | output | 1 | Registered decision is valid |
| commit_ok | output | 1 | Instruction may commit |
| squash | output | 1 | Instruction is nullified |

## Verification
The checker watches, on every cycle, the one-cycle link from insn_valid to commit_valid and the exclusivity of commit and squash. It also checks that index 0 always commits and that same-cycle forwarding follows the current compare, including the case where both destinations name the same flag. Whether stored flags hold their values over long idle stretches, and whether reset clears every flag, can only be shown by the bench's scenarios. The bench covers these with a full sweep of indices after reset and long random streams checked against a shadow model.

// File: rtl/pred_guard_file.sv
module pred_guard_file #(
  parameter int NUM_PREDS = 64,
  localparam int IDX_W = $clog2(NUM_PREDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we,
  input  logic [IDX_W-1:0] cmp_dst_t,
  input  logic [IDX_W-1:0] cmp_dst_f,
  input  logic             cmp_result,
  input  logic             insn_valid,
  input  logic [IDX_W-1:0] insn_guard,
  output logic             commit_valid,
  output logic             commit_ok,
  output logic             squash
);

  logic [NUM_PREDS-1:1] flag_q;
  logic [NUM_PREDS-1:0] flag_all;

  assign flag_all = {flag_q, 1'b1};

  for (genvar i = 1; i < NUM_PREDS; i++) begin : g_flag
    logic hit_t, hit_f;
    assign hit_t = cmp_we && (cmp_dst_t == IDX_W'(i));
    assign hit_f = cmp_we && (cmp_dst_f == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)     flag_q[i] <= 1'b0;
      else if (hit_t) flag_q[i] <= cmp_result;
      else if (hit_f) flag_q[i] <= ~cmp_result;
    end
  end

  logic guard_zero, fwd_t, fwd_f, guard_val;

  assign guard_zero = (insn_guard == '0);
  assign fwd_t      = cmp_we && (cmp_dst_t == insn_guard);
  assign fwd_f      = cmp_we && (cmp_dst_f == insn_guard);

  always_comb begin
    if (guard_zero)  guard_val = 1'b1;
    else if (fwd_t)  guard_val = cmp_result;
    else if (fwd_f)  guard_val = ~cmp_result;
    else             guard_val = flag_all[insn_guard];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      commit_ok    <= 1'b0;
      squash       <= 1'b0;
    end else begin
      commit_valid <= insn_valid;
      commit_ok    <= insn_valid && guard_val;
      squash       <= insn_valid && !guard_val;
    end
  end

endmodule

module pred_guard_file_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_we,
  input logic [IDX_W-1:0] cmp_dst_t,
  input logic [IDX_W-1:0] cmp_dst_f,
  input logic             cmp_result,
  input logic             insn_valid,
  input logic [IDX_W-1:0] insn_guard,
  input logic             commit_valid,
  input logic             commit_ok,
  input logic             squash
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> commit_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !commit_valid);

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> (commit_ok ^ squash));

  // R3
  quiet_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |-> (!commit_ok && !squash));

  // R4
  zero_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_guard == '0) |=> commit_ok);

  // R6
  fwd_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && cmp_we && insn_guard != '0 && cmp_dst_t == insn_guard)
      |=> (commit_ok == $past(cmp_result)));

  // R6
  fwd_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && cmp_we && insn_guard != '0 && cmp_dst_f == insn_guard
     && cmp_dst_t != insn_guard) |=> (squash == $past(cmp_result)));

  // R7
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && cmp_we && insn_guard != '0 && cmp_dst_f == insn_guard
     && cmp_dst_t == insn_guard) |=> (commit_ok == $past(cmp_result)));

endmodule

bind pred_guard_file pred_guard_file_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_dst_t(cmp_dst_t),
  .cmp_dst_f(cmp_dst_f), .cmp_result(cmp_result), .insn_valid(insn_valid),
  .insn_guard(insn_guard), .commit_valid(commit_valid),
  .commit_ok(commit_ok), .squash(squash)
);

// File: tb/test_pred_guard_file.sv
module test_pred_guard_file;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_we = 1'b0, cmp_result = 1'b0, insn_valid = 1'b0;
  logic [5:0] cmp_dst_t = '0, cmp_dst_f = '0, insn_guard = '0;
  logic commit_valid, commit_ok, squash;

  int checks = 0, failures = 0;
  logic model [64];
  logic exp_v = 1'b0, exp_g = 1'b0;
  string exp_tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  pred_guard_file i_pred_guard_file (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_dst_t(cmp_dst_t),
    .cmp_dst_f(cmp_dst_f), .cmp_result(cmp_result), .insn_valid(insn_valid),
    .insn_guard(insn_guard), .commit_valid(commit_valid),
    .commit_ok(commit_ok), .squash(squash)
  );

  function automatic logic guard_of(logic we, logic [5:0] dt, logic [5:0] df,
                                    logic res, logic [5:0] g);
    if (g == 0) return 1'b1;
    if (we && dt == g) return res;
    if (we && df == g) return ~res;
    return model[g];
  endfunction

  function automatic string tag_of(logic we, logic [5:0] dt, logic [5:0] df,
                                   logic [5:0] g);
    if (g == 0) return "R4";
    if (we && dt == g && df == g) return "R7";
    if (we && (dt == g || df == g)) return "R6";
    return "R5/R8";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic verify();
    chk(commit_valid == exp_v, "R2", commit_valid, exp_v);
    if (exp_v) begin
      chk(commit_ok == exp_g, exp_tag, commit_ok, exp_g);
      chk(squash == !exp_g, "R3", squash, !exp_g);
    end else begin
      chk(!commit_ok && !squash, "R3", {commit_ok, squash}, 0);
    end
  endtask

  task automatic step(logic we, logic [5:0] dt, logic [5:0] df, logic res,
                      logic v, logic [5:0] g);
    @(negedge clk);
    verify();
    cmp_we = we; cmp_dst_t = dt; cmp_dst_f = df; cmp_result = res;
    insn_valid = v; insn_guard = g;
    exp_v = v;
    exp_g = guard_of(we, dt, df, res, g);
    exp_tag = tag_of(we, dt, df, g);
    if (we) begin
      if (df != 0) model[df] = ~res;
      if (dt != 0) model[dt] = res;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    repeat (3) @(negedge clk);
    chk(!commit_valid && !commit_ok && !squash, "R1", commit_ok, 0);
    rst_n = 1'b1;
    // R1: sweep every index after reset
    for (int i = 0; i < 64; i++) step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'(i));
    // R4: write to index 0 ignored
    step(1'b1, 6'd0, 6'd0, 1'b0, 1'b0, 6'd0);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd0);
    // R5: pair write then read both
    step(1'b1, 6'd5, 6'd9, 1'b1, 1'b0, 6'd0);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd5);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd9);
    // R6: forwarding on both senses
    step(1'b1, 6'd12, 6'd13, 1'b1, 1'b1, 6'd12);
    step(1'b1, 6'd12, 6'd13, 1'b0, 1'b1, 6'd13);
    // R7: same destination, both polarities, forwarded and stored
    step(1'b1, 6'd20, 6'd20, 1'b1, 1'b1, 6'd20);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd20);
    step(1'b1, 6'd21, 6'd21, 1'b0, 1'b1, 6'd21);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd21);
    step(1'b1, 6'd63, 6'd1, 1'b1, 1'b0, 6'd0);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd63);
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'd1);
    // random mix, R8 holds over idle cycles
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] g;
      g = 6'($urandom_range(0, 63));
      step(($urandom_range(0, 3) == 0), 6'($urandom_range(0, 63)),
           6'($urandom_range(0, 63)), 1'($urandom),
           ($urandom_range(0, 4) != 0),
           ($urandom_range(0, 5) == 0) ? cmp_dst_t : g);
    end
    // R8: read all after random stream without writes
    for (int i = 0; i < 64; i++) step(1'b0, 6'd0, 6'd0, 1'b0, 1'b1, 6'(i));
    step(1'b0, 6'd0, 6'd0, 1'b0, 1'b0, 6'd0);
    @(negedge clk);
    verify();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule